// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This unit adds or subtracts two 32-bit operands that hold packed lanes. The lanes can be four 8-bit values, two 16-bit values or one 32-bit value. Carries never pass from one lane to the next. Each lane can be treated as signed or unsigned. The unit has three result styles:

- wrapping: the low bits of the exact result are kept;
- saturating: each lane is clamped on its own to the limits of its type;
- halving: the exact sum or difference is shifted right by one, with an optional +1 added before the shift.

An operation is presented with a valid strobe, and its result appears in an output register one cycle later. Two sticky flags record lane overflow: one for the add class and one for the subtract class. These flags are updated by the non-halving operations only. They stay set until a clear strobe arrives.

Top module: `simd_addsub`

## Requirements
- R1: During reset (`rst_n` low at a clock edge), `out_valid`, `result` and `ovf_sticky` all become 0.
- R2: A request with `in_valid` high at edge k puts its result on `result`, with `out_valid` high, after edge k. When `in_valid` is low at an edge, `out_valid` goes low and `result` holds its previous value.
- R3: `lane_fmt` selects the lane layout. Value 0 gives four 8-bit lanes, 1 gives two 16-bit lanes, and 2 or 3 give one 32-bit lane. In wrapping mode, each lane returns the low bits of its own sum or difference, and no carry or borrow passes between lanes.
- R4: In unsigned saturating mode (`is_signed`=0, `sat_en`=1, `halve_en`=0), a lane add that overflows gives all ones. A lane subtract that borrows gives 0.
- R5: In signed saturating mode, a lane that overflows gives the most negative lane value if the exact result is negative, and the most positive lane value otherwise.
- R6: With `halve_en`=1, each lane returns floor((a±b)/2), computed without overflow. The operands are signed or unsigned according to `is_signed`.
- R7: With `halve_en`=1 and `round_en`=1, each lane returns floor((a±b+1)/2).
- R8: A valid non-halving request sets a sticky bit if any lane overflows, whether or not saturation is on. An add sets `ovf_sticky[0]` and a subtract sets `ovf_sticky[1]`. Overflow means a carry out for unsigned add, a borrow for unsigned subtract, and a result outside the lane's range for signed operation.
- R9: A halving request never changes `ovf_sticky`.
- R10: `flag_clr` high at an edge clears both sticky bits. If a request sets a bit at the same edge, that bit ends up set.
- R11: `round_en` has no effect when `halve_en` is 0. `sat_en` has no effect when `halve_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| lane_fmt | input | 2 | Lane layout: 0 = 4x8, 1 = 2x16, 2/3 = 1x32 |
| is_signed | input | 1 | Lanes treated as two's-complement |
| sat_en | input | 1 | Clamp overflowing lanes |
| halve_en | input | 1 | Halving result style |
| round_en | input | 1 | Add one before the halving shift |
| opa | input | 32 | First packed operand |
| opb | input | 32 | Second packed operand |
| flag_clr | input | 1 | Clear both sticky flags |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Registered packed result |
| ovf_sticky | output | 2 | Sticky overflow: bit 0 add class, bit 1 subtract class |

## Verification
Both `result` and `out_valid` are due one clock edge after the request edge. The sticky flags change at that same edge. The bench drives each request on a falling edge and checks all three outputs on the next falling edge, so every check sees exactly one rising edge after its stimulus. Idle cycles check that `out_valid` drops and that `result` holds. Clear strobes are checked both on their own and together with an overflowing request.

// File: rtl/simd_addsub_pkg.sv
// Package: shared constants for the packed add/subtract unit.
// Assumes the data word is four base lanes wide.
package simd_addsub_pkg;
    localparam int DATA_W  = 32;
    localparam int BASE_W  = 8;
    localparam int NUM_FMT = 3;

    typedef enum logic [1:0] {
        FMT_B8  = 2'd0,
        FMT_H16 = 2'd1,
        FMT_W32 = 2'd2
    } lane_fmt_e;

    // Map the 2-bit format code onto a layout index; code 3 aliases the word layout.
    function automatic int unsigned fmt_index(input logic [1:0] code);
        return (code == 2'd0) ? 0 : (code == 2'd1) ? 1 : 2;
    endfunction
endpackage

// File: rtl/simd_lane.sv
// Module: one arithmetic lane of width LW.
// Computes wrapping, saturating or halving add/subtract of one lane, plus an
// overflow indication. Purely combinational; assumes LW >= 2.
module simd_lane #(
    parameter int LW = 8
) (
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic          sub,
    input  logic          sgn,
    input  logic          sat,
    input  logic          halve,
    input  logic          rnd,
    output logic [LW-1:0] res,
    output logic          ovf
);
    localparam int EW = LW + 2;

    logic [EW-1:0] ext_a, ext_b, exact, rounded;
    logic [LW-1:0] clamp_val;

    // Widen operands by two bits so the exact result and the rounding step never overflow.
    always_comb begin
        ext_a   = sgn ? {{2{a[LW-1]}}, a} : {2'b00, a};
        ext_b   = sgn ? {{2{b[LW-1]}}, b} : {2'b00, b};
        exact   = sub ? (ext_a - ext_b) : (ext_a + ext_b);
        rounded = exact + {{(EW-1){1'b0}}, rnd};
    end

    // Detect lane overflow: range check for signed, carry/borrow bit for unsigned.
    always_comb begin
        if (sgn) ovf = (exact[LW] != exact[LW-1]);
        else     ovf = exact[LW];
    end

    // Choose the clamp limit from the sign mode and the direction of overflow.
    always_comb begin
        if (sgn)      clamp_val = exact[EW-1] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
        else if (sub) clamp_val = '0;
        else          clamp_val = '1;
    end

    // Pick the lane result for the requested style; halving takes precedence over saturation.
    always_comb begin
        if (halve)           res = rounded[LW:1];
        else if (sat && ovf) res = clamp_val;
        else                 res = exact[LW-1:0];
    end
endmodule

// File: rtl/simd_sticky.sv
// Module: sticky overflow flags, one per operation class (add, subtract).
// A set request at the same edge as a clear wins for its own bit.
module simd_sticky (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_en,
    input  logic       set_sub,
    output logic [1:0] flags
);
    logic [1:0] set_mask;

    // Decode which class bit the current request would set.
    always_comb set_mask = set_en ? (set_sub ? 2'b10 : 2'b01) : 2'b00;

    // Hold, clear or set the sticky bits.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= 2'b00;
        else        flags <= (clr ? 2'b00 : flags) | set_mask;
    end
endmodule

// File: rtl/simd_addsub.sv
// Module: packed SIMD add/subtract unit (top).
// Runs every lane layout in parallel, selects the one requested, and
// registers the result one cycle after a valid request. Assumes DATA_W is a
// multiple of 4*BASE_W_P so that each layout fills the word exactly.
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int DATA_W_P = DATA_W,
    parameter int BASE_W_P = BASE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                op_sub,
    input  logic [1:0]          lane_fmt,
    input  logic                is_signed,
    input  logic                sat_en,
    input  logic                halve_en,
    input  logic                round_en,
    input  logic [DATA_W_P-1:0] opa,
    input  logic [DATA_W_P-1:0] opb,
    input  logic                flag_clr,
    output logic                out_valid,
    output logic [DATA_W_P-1:0] result,
    output logic [1:0]          ovf_sticky
);
    localparam int MAX_LANES = DATA_W_P / BASE_W_P;

    logic [NUM_FMT-1:0][DATA_W_P-1:0] fmt_res;
    logic [NUM_FMT-1:0]               fmt_ovf;
    logic [DATA_W_P-1:0]              sel_res;
    logic                             sel_ovf;
    logic                             rnd_q;

    // Rounding is only meaningful for the halving style.
    always_comb rnd_q = halve_en & round_en;

    for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
        localparam int LW = BASE_W_P << f;
        localparam int LN = MAX_LANES >> f;
        logic [LN-1:0] lane_ovf;
        for (genvar l = 0; l < LN; l++) begin : g_lane
            simd_lane #(.LW(LW)) u_lane (
                .a     (opa[l*LW +: LW]),
                .b     (opb[l*LW +: LW]),
                .sub   (op_sub),
                .sgn   (is_signed),
                .sat   (sat_en),
                .halve (halve_en),
                .rnd   (rnd_q),
                .res   (fmt_res[f][l*LW +: LW]),
                .ovf   (lane_ovf[l])
            );
        end
        // Any lane overflowing in this layout flags the layout.
        assign fmt_ovf[f] = |lane_ovf;
    end

    // Select the layout named by the format code.
    always_comb begin
        sel_res = fmt_res[fmt_index(lane_fmt)];
        sel_ovf = fmt_ovf[fmt_index(lane_fmt)];
    end

    // Register the result and its strobe; the result holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= sel_res;
        end
    end

    simd_sticky u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (flag_clr),
        .set_en  (in_valid & ~halve_en & sel_ovf),
        .set_sub (op_sub),
        .flags   (ovf_sticky)
    );
endmodule

// File: rtl/simd_addsub_checker.sv
// Module: property checker for simd_addsub, attached with bind below.
// Watches ports only; assumes the synchronous active-low reset of the top.
module simd_addsub_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        op_sub,
    input logic [1:0]  lane_fmt,
    input logic        is_signed,
    input logic        sat_en,
    input logic        halve_en,
    input logic [31:0] opa,
    input logic        flag_clr,
    input logic        out_valid,
    input logic [31:0] result,
    input logic [1:0]  ovf_sticky
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_sticky_only_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((ovf_sticky & $past(ovf_sticky)) == $past(ovf_sticky)));

    assert_halve_keeps_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && halve_en && !flag_clr) |=> $stable(ovf_sticky));

    assert_usat_add_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !halve_en && sat_en && !is_signed && !op_sub && lane_fmt == 2'd0)
        |=> (result[7:0] >= $past(opa[7:0])));
endmodule

bind simd_addsub simd_addsub_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sub     (op_sub),
    .lane_fmt   (lane_fmt),
    .is_signed  (is_signed),
    .sat_en     (sat_en),
    .halve_en   (halve_en),
    .opa        (opa),
    .flag_clr   (flag_clr),
    .out_valid  (out_valid),
    .result     (result),
    .ovf_sticky (ovf_sticky)
);

// File: tb/simd_addsub_test.sv
// Bench: directed corner cases plus seeded random requests, checked against
// a lane-by-lane reference computed with wide integers.
module simd_addsub_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [1:0]  lane_fmt = 2'd0;
    logic        is_signed = 1'b0;
    logic        sat_en = 1'b0;
    logic        halve_en = 1'b0;
    logic        round_en = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        flag_clr = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic [1:0]  ovf_sticky;

    int checks = 0;
    int fails = 0;
    logic [1:0]  sticky_model = 2'b00;
    logic [31:0] last_res = '0;

    always #4 clk = ~clk;

    simd_addsub uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .lane_fmt(lane_fmt), .is_signed(is_signed), .sat_en(sat_en),
        .halve_en(halve_en), .round_en(round_en), .opa(opa), .opb(opb),
        .flag_clr(flag_clr), .out_valid(out_valid), .result(result),
        .ovf_sticky(ovf_sticky)
    );

    // Reference result for one request; ovf reports any lane overflow.
    function automatic logic [31:0] ref_calc(input logic [31:0] a, input logic [31:0] b,
        input logic sub, input logic [1:0] fmt, input logic sg, input logic st,
        input logic hv, input logic rd, output logic ovf);
        int lw, ln;
        logic [31:0] r;
        lw = (fmt == 2'd0) ? 8 : (fmt == 2'd1) ? 16 : 32;
        ln = 32 / lw;
        r = '0;
        ovf = 1'b0;
        for (int l = 0; l < ln; l++) begin
            longint av, bv, s, lo, hi, v, m;
            m  = longint'(1) << lw;
            av = longint'((a >> (l*lw))) & (m - 1);
            bv = longint'((b >> (l*lw))) & (m - 1);
            if (sg) begin
                if (av >= m/2) av -= m;
                if (bv >= m/2) bv -= m;
                lo = -(m/2); hi = m/2 - 1;
            end else begin
                lo = 0; hi = m - 1;
            end
            s = sub ? av - bv : av + bv;
            if (s < lo || s > hi) ovf = 1'b1;
            if (hv)                   v = (s + (rd ? 1 : 0)) >>> 1;
            else if (st && s > hi)    v = hi;
            else if (st && s < lo)    v = lo;
            else                      v = s;
            r = r | (32'(v & (m - 1)) << (l*lw));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one request at a falling edge and check all outputs one rising edge later.
    task automatic do_op(input string req, input logic sub, input logic [1:0] fmt,
        input logic sg, input logic st, input logic hv, input logic rd,
        input logic [31:0] a, input logic [31:0] b, input logic clr);
        logic [31:0] exp;
        logic ov;
        exp = ref_calc(a, b, sub, fmt, sg, st, hv, rd, ov);
        in_valid = 1'b1; op_sub = sub; lane_fmt = fmt; is_signed = sg;
        sat_en = st; halve_en = hv; round_en = rd; opa = a; opb = b; flag_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
        if (clr) sticky_model = 2'b00;
        if (!hv && ov) sticky_model[sub] = 1'b1;
        last_res = exp;
        check(req, result, exp);
        check({req, " strobe R2"}, {31'd0, out_valid}, 32'd1);
        check({req, " sticky R8"}, {30'd0, ovf_sticky}, {30'd0, sticky_model});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset result", result, 32'd0);
        check("R1 reset sticky", {30'd0, ovf_sticky}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: wrapping, no carry across lanes
        do_op("R3 b8 wrap add", 0, 2'd0, 0, 0, 0, 0, 32'h80FF_01FF, 32'h8001_01FF, 0);
        check("R3 b8 lanes", last_res, 32'h0000_02FE);
        do_op("R3 h16 wrap sub", 1, 2'd1, 0, 0, 0, 0, 32'h0000_0005, 32'h0001_0006, 1);
        do_op("R3 w32 code3 add", 0, 2'd3, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h0000_0001, 1);
        check("R3 word carry", last_res, 32'h8000_0000);
        // R4: unsigned saturation
        do_op("R4 usat add", 0, 2'd0, 0, 1, 0, 0, 32'hF010_FF00, 32'h20F0_0100, 0);
        check("R4 usat add value", last_res, 32'hFFFF_FF00);
        do_op("R4 usat sub", 1, 2'd0, 0, 1, 0, 0, 32'h0510_0003, 32'h0601_0004, 0);
        check("R4 usat sub value", last_res, 32'h000F_0000);
        // R5: signed saturation
        do_op("R5 ssat w add", 0, 2'd2, 1, 1, 0, 0, 32'h7FFF_FFF0, 32'h0000_0100, 1);
        check("R5 max clamp", last_res, 32'h7FFF_FFFF);
        do_op("R5 ssat w sub", 1, 2'd2, 1, 1, 0, 0, 32'h8000_0000, 32'h0000_0001, 0);
        check("R5 min clamp", last_res, 32'h8000_0000);
        do_op("R5 ssat h16", 0, 2'd1, 1, 1, 0, 0, 32'h8000_7000, 32'h8000_1000, 0);
        check("R5 h16 lanes", last_res, 32'h8000_7FFF);
        // R6/R7: halving, with and without rounding; R9: sticky unchanged
        do_op("R6 halve w sub", 1, 2'd2, 1, 0, 1, 0, 32'h7FFF_FFFF, 32'h8000_0000, 0);
        check("R6 halve value", last_res, 32'h7FFF_FFFF);
        do_op("R7 round h16", 0, 2'd1, 1, 0, 1, 1, 32'h0003_FFFF, 32'h0000_0000, 0);
        check("R7 round value", last_res, 32'h0002_0000);
        do_op("R9 halve overflow", 0, 2'd1, 1, 1, 1, 0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1);
        check("R9 sticky cleared only", {30'd0, ovf_sticky}, 32'd0);
        // R11: round ignored without halve, sat ignored with halve
        do_op("R11 round ignored", 0, 2'd0, 0, 0, 0, 1, 32'h0101_0101, 32'h0101_0101, 0);
        check("R11 no round", last_res, 32'h0202_0202);
        do_op("R11 sat ignored", 0, 2'd0, 0, 1, 1, 0, 32'hFF00_0000, 32'hFF00_0000, 0);
        check("R11 halve wins", last_res, 32'hFF00_0000);
        // R10: clear together with a setting request
        do_op("R10 clr+set", 1, 2'd0, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_0001, 1);
        check("R10 sub bit kept", {30'd0, ovf_sticky}, 32'd2);
        // R2: idle cycle
        @(negedge clk);
        check("R2 idle strobe", {31'd0, out_valid}, 32'd0);
        check("R2 idle hold", result, last_res);

        // Random mix
        begin
            int unsigned seed = 32'd1234;
            void'($urandom(seed));
            for (int i = 0; i < 400; i++) begin
                logic [7:0] c;
                c = 8'($urandom());
                do_op("R3-rand", c[0], c[2:1], c[3], c[4], c[5], c[6],
                      $urandom(), $urandom(), (c[7] && ($urandom() % 4 == 0)));
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule